// File: doc/BRIEF.md
# Block Transfer DMA Engine

This single-channel engine moves a block of words between memory and one peripheral without the processor doing the work. The addresses and strobes are driven by the engine and the data flows directly between the two. Software sets a start address, a word count and a control word through a small register port, then lets the peripheral take over. The peripheral raises a request. The engine then either borrows the bus through a hold/grant handshake or freezes the processor clock for single cycles. On each word it places the current address on the bus, acknowledges the peripheral and pulses the matching read and write strobes.

Two operating modes exist. In burst mode the engine holds the bus for as long as the peripheral keeps requesting, one word per cycle, until the count runs out. If the request drops early, the engine pauses and keeps its position for later. In steal mode no hold is requested. For each word the engine pulls the processor clock enable low for exactly one cycle, and the processor clock is meant to be the AND of the system clock and that enable. A done flag in the status word marks the end of a block.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, hold, acknowledge, bus drive and all four strobes are low, the processor clock enable is high, and every register reads zero.
- R2: cpu_sel picks the register for both reads and writes: 0 address, 1 word count, 2 control (bit 0 mode, 1 = steal; bit 1 direction, 1 = memory to peripheral), 3 status (bit 0 done, bit 1 busy). cpu_rdata shows the selected register in the same cycle.
- R3: In burst mode, a request with a nonzero count raises hold one cycle later. Bus drive, acknowledge and strobes stay low until hlda has been sampled high.
- R4: While a word moves, bus_oe and dack are high and bus_addr equals the address register. The strobes are mem_rd with io_wr when direction is 1, and io_rd with mem_wr when it is 0. With bus_oe low, all strobes are low and bus_addr is zero.
- R5: Each word moved raises the address by one and lowers the count by one.
- R6: When the last word moves, done is set. Hold, bus drive and acknowledge are low in the following cycle.
- R7: In burst mode with the request held, words move on consecutive cycles without hold dropping.
- R8: In steal mode, cpu_clk_en is low in exactly the cycles where a word moves, never in two cycles in a row, and hold stays low.
- R9: If the request drops during a burst, the word in progress completes and hold is released. The next request continues from the saved address and count.
- R10: Writes to address, count or control are ignored while the engine is busy or in the cycle it starts.
- R11: Writing status with bit 0 set clears done. If the last word moves in the same cycle, done stays set.
- R12: With a zero count, a request is ignored: hold stays low and the clock enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 2 | Register select |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | AW | Register write data |
| cpu_rdata | output | AW | Selected register contents |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Acknowledge to the peripheral, one per word |
| hold | output | 1 | Bus release request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| cpu_clk_en | output | 1 | Processor clock enable, low in a stolen cycle |
| bus_oe | output | 1 | Engine is driving address and strobes |
| bus_addr | output | AW | Transfer address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |

## Verification
Two things can land on one cycle. The first pair is the final word of a block setting done while software writes a one to clear it. The bench waits until its own model shows one word left in a burst and places the clearing write on exactly that cycle, then expects done to read back as one. The second pair is a software write to the address or count registers while a word is stepping them. Here the bench expects the stepped values, with the write lost.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_MOVE  = 2'd2,
    ST_STEAL = 2'd3
  } dma_st_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    rw_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          lock,
  input  logic          busy,
  input  logic          word_step,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          mode_q,
  output logic          dir_q,
  output logic          done_q,
  output logic          cnt_nz,
  output logic          cnt_last,
  output logic          last_step,
  output logic [AW-1:0] rd_data
);

  localparam int PADW = AW - CW;

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_after(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  function automatic logic is_final(input logic [CW-1:0] c);
    return c == CW'(1);
  endfunction

  logic          clr_req;
  logic [AW-1:0] cnt_ext;

  assign cnt_nz    = (cnt_q != '0);
  assign cnt_last  = is_final(cnt_q);
  assign last_step = word_step && cnt_last;
  assign clr_req   = wr_en && (rw_sel == SEL_STAT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (word_step) begin
      addr_q <= addr_after(addr_q);
      cnt_q  <= cnt_after(cnt_q);
    end else if (wr_en && !lock) begin
      case (rw_sel)
        SEL_ADDR: addr_q <= wr_data;
        SEL_CNT:  cnt_q  <= wr_data[CW-1:0];
        SEL_CTRL: begin
          mode_q <= wr_data[0];
          dir_q  <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_q <= 1'b0;
    else if (last_step) done_q <= 1'b1;
    else if (clr_req)   done_q <= 1'b0;
  end

  generate
    if (PADW > 0) begin : g_pad
      assign cnt_ext = {{PADW{1'b0}}, cnt_q};
    end else begin : g_nopad
      assign cnt_ext = cnt_q;
    end
  endgenerate

  always_comb begin
    case (rw_sel)
      SEL_ADDR: rd_data = addr_q;
      SEL_CNT:  rd_data = cnt_ext;
      SEL_CTRL: rd_data = {{(AW-2){1'b0}}, dir_q, mode_q};
      default:  rd_data = {{(AW-2){1'b0}}, busy, done_q};
    endcase
  end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_xfer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    dreq,
  input  logic    hlda,
  input  logic    steal_mode,
  input  logic    cnt_nz,
  input  logic    cnt_last,
  output dma_st_e state_q,
  output logic    busy,
  output logic    start,
  output logic    word_step
);

  dma_st_e state_d;

  assign busy      = (state_q != ST_IDLE);
  assign start     = (state_q == ST_IDLE) && dreq && cnt_nz;
  assign word_step = (state_q == ST_MOVE) || (state_q == ST_STEAL);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start) state_d = steal_mode ? ST_STEAL : ST_WAIT;
      end
      ST_WAIT: begin
        if (!dreq || !cnt_nz) state_d = ST_IDLE;
        else if (hlda)        state_d = ST_MOVE;
      end
      ST_MOVE: begin
        if (cnt_last || !dreq) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/dma_xfer_bus.sv
module dma_xfer_bus
  import dma_xfer_pkg::*;
#(
  parameter int AW = 16
) (
  input  dma_st_e       state_q,
  input  logic          dir_q,
  input  logic [AW-1:0] addr_q,
  output logic          hold,
  output logic          bus_oe,
  output logic [AW-1:0] bus_addr,
  output logic          dack,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr,
  output logic          cpu_clk_en
);

  logic moving;

  assign moving     = (state_q == ST_MOVE) || (state_q == ST_STEAL);
  assign hold       = (state_q == ST_WAIT) || (state_q == ST_MOVE);
  assign cpu_clk_en = (state_q != ST_STEAL);
  assign bus_oe     = moving;
  assign dack       = moving;
  assign bus_addr   = moving ? addr_q : '0;
  assign mem_rd     = moving && dir_q;
  assign io_wr      = moving && dir_q;
  assign io_rd      = moving && !dir_q;
  assign mem_wr     = moving && !dir_q;

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cpu_sel,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_wdata,
  output logic [AW-1:0] cpu_rdata,
  input  logic          dreq,
  output logic          dack,
  output logic          hold,
  input  logic          hlda,
  output logic          cpu_clk_en,
  output logic          bus_oe,
  output logic [AW-1:0] bus_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr
);

  dma_st_e       state_q;
  logic          busy;
  logic          start;
  logic          lock;
  logic          word_step;
  logic          last_step;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          mode_q;
  logic          dir_q;
  logic          done_q;
  logic          cnt_nz;
  logic          cnt_last;

  assign lock = busy || start;

  dma_xfer_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cpu_wr),
    .rw_sel    (cpu_sel),
    .wr_data   (cpu_wdata),
    .lock      (lock),
    .busy      (busy),
    .word_step (word_step),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .mode_q    (mode_q),
    .dir_q     (dir_q),
    .done_q    (done_q),
    .cnt_nz    (cnt_nz),
    .cnt_last  (cnt_last),
    .last_step (last_step),
    .rd_data   (cpu_rdata)
  );

  dma_xfer_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .dreq       (dreq),
    .hlda       (hlda),
    .steal_mode (mode_q),
    .cnt_nz     (cnt_nz),
    .cnt_last   (cnt_last),
    .state_q    (state_q),
    .busy       (busy),
    .start      (start),
    .word_step  (word_step)
  );

  dma_xfer_bus #(.AW(AW)) u_bus (
    .state_q    (state_q),
    .dir_q      (dir_q),
    .addr_q     (addr_q),
    .hold       (hold),
    .bus_oe     (bus_oe),
    .bus_addr   (bus_addr),
    .dack       (dack),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .cpu_clk_en (cpu_clk_en)
  );

endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          hlda,
  input logic          cpu_clk_en,
  input logic          bus_oe,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          io_rd,
  input logic          io_wr,
  input logic          busy,
  input logic          word_step,
  input logic          last_step,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] cnt_q,
  input logic          done_q
);

  AST_GRANT_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (bus_oe && cpu_clk_en) |-> hlda); // R3
  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> (($countones({mem_rd, mem_wr, io_rd, io_wr}) == 2) && (mem_rd != mem_wr))); // R4
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !bus_oe |-> !(mem_rd || mem_wr || io_rd || io_wr)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) word_step |=> (addr_q == $past(addr_q) + AW'(1))); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) word_step |=> (cnt_q == $past(cnt_q) - CW'(1))); // R5
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n) last_step |=> done_q); // R6
  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) last_step |=> (!hold && !bus_oe)); // R6
  AST_STEAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !cpu_clk_en |=> cpu_clk_en); // R8
  AST_STEAL_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cpu_clk_en |-> !hold); // R8
  AST_LOCKED_REGS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !word_step) |=> ($stable(addr_q) && $stable(cnt_q))); // R10
  AST_NO_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (!busy && (cnt_q == '0)) |=> (!hold && cpu_clk_en)); // R12

endmodule

bind dma_xfer_ctrl dma_xfer_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_dma_xfer_ctrl.sv
module sim_dma_xfer_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int WD_LIMIT = 20000;

  logic          clk;
  logic          rst_n;
  logic [1:0]    cpu_sel;
  logic          cpu_wr;
  logic [AW-1:0] cpu_wdata;
  logic [AW-1:0] cpu_rdata;
  logic          dreq;
  logic          dack;
  logic          hold;
  logic          hlda;
  logic          cpu_clk_en;
  logic          bus_oe;
  logic [AW-1:0] bus_addr;
  logic          mem_rd, mem_wr, io_rd, io_wr;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit cmp_on = 0;

  dma_xfer_ctrl #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dreq(dreq), .dack(dack),
    .hold(hold), .hlda(hlda), .cpu_clk_en(cpu_clk_en), .bus_oe(bus_oe),
    .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // processor: grants the bus 'lag' cycles after it sees hold
  logic [3:0] hpipe = '0;
  int lag = 0;
  always @(negedge clk) hpipe <= {hpipe[2:0], hold};
  assign hlda = hpipe[lag];

  // reference model: 0 idle, 1 waiting for grant, 2 burst word, 3 stolen word
  logic [AW-1:0] m_addr = '0;
  logic [CW-1:0] m_cnt = '0;
  logic m_mode = 0, m_dir = 0, m_done = 0;
  int ph = 0;

  always @(posedge clk) begin
    logic [AW-1:0] na;
    logic [CW-1:0] nc;
    logic nmode, ndir, nd, st, act, word;
    int nph;
    if (!rst_n) begin
      m_addr = '0; m_cnt = '0; m_mode = 0; m_dir = 0; m_done = 0; ph = 0;
    end else begin
      st = (ph == 0) && dreq && (m_cnt != 0);
      act = (ph != 0) || st;
      word = (ph == 2) || (ph == 3);
      na = m_addr; nc = m_cnt; nmode = m_mode; ndir = m_dir; nd = m_done;
      if (cpu_wr && cpu_sel == 2'd3 && cpu_wdata[0]) nd = 0;
      if (cpu_wr && !act) begin
        if (cpu_sel == 2'd0) na = cpu_wdata;
        if (cpu_sel == 2'd1) nc = cpu_wdata[CW-1:0];
        if (cpu_sel == 2'd2) begin nmode = cpu_wdata[0]; ndir = cpu_wdata[1]; end
      end
      if (word) begin
        na = m_addr + 1;
        nc = m_cnt - 1;
        if (m_cnt == 1) nd = 1;
      end
      nph = ph;
      case (ph)
        0: if (st) nph = m_mode ? 3 : 1;
        1: if (!dreq || m_cnt == 0) nph = 0; else if (hlda) nph = 2;
        2: if (m_cnt == 1 || !dreq) nph = 0;
        default: nph = 0;
      endcase
      m_addr = na; m_cnt = nc; m_mode = nmode; m_dir = ndir; m_done = nd; ph = nph;
    end
  end

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic oe;
    logic [AW-1:0] erd;
    #(CLK_P/4);
    if (cmp_on) begin
      oe = (ph == 2) || (ph == 3);
      check("R3 hold", AW'(hold), AW'((ph == 1) || (ph == 2)));
      check("R4 bus_oe", AW'(bus_oe), AW'(oe));
      check("R4 dack", AW'(dack), AW'(oe));
      check("R4 bus_addr", bus_addr, oe ? m_addr : '0);
      check("R4 strobes", AW'({mem_rd, mem_wr, io_rd, io_wr}),
            AW'({oe && m_dir, oe && !m_dir, oe && !m_dir, oe && m_dir}));
      check("R8 cpu_clk_en", AW'(cpu_clk_en), AW'(ph != 3));
      case (cpu_sel)
        2'd0: erd = m_addr;
        2'd1: erd = AW'(m_cnt);
        2'd2: erd = AW'({m_dir, m_mode});
        default: erd = AW'({ph != 0, m_done});
      endcase
      check("R2 cpu_rdata", cpu_rdata, erd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [AW-1:0] v);
    @(negedge clk);
    cpu_sel = s; cpu_wdata = v; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] s, input logic [AW-1:0] exp, input string tag);
    @(negedge clk);
    cpu_sel = s;
    #(CLK_P/4);
    check(tag, cpu_rdata, exp);
  endtask

  initial begin
    int n_oe, rises, n_low, pairs;
    logic prev;
    rst_n = 0; dreq = 0; cpu_wr = 0; cpu_sel = 0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;

    // R1 reset state
    check("R1 hold", AW'(hold), '0);
    check("R1 cpu_clk_en", AW'(cpu_clk_en), AW'(1));
    check("R1 bus_oe", AW'(bus_oe), '0);
    rd_expect(2'd0, '0, "R1 addr");
    rd_expect(2'd1, '0, "R1 count");
    rd_expect(2'd2, '0, "R1 ctrl");
    rd_expect(2'd3, '0, "R1 status");

    // burst, memory to peripheral, grant without lag
    wr(2'd0, 16'h0100); wr(2'd1, 16'd4); wr(2'd2, 16'b10);
    rd_expect(2'd0, 16'h0100, "R2 addr readback");
    rd_expect(2'd2, 16'h0002, "R2 ctrl readback");
    @(negedge clk); dreq = 1;
    n_oe = 0; rises = 0; prev = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #(CLK_P/4);
      if (bus_oe) begin
        n_oe++;
        check("R4 read mem / write io", AW'({mem_rd, io_wr}), AW'(2'b11));
      end
      if (bus_oe && !prev) rises++;
      prev = bus_oe;
    end
    check("R7 words moved", AW'(n_oe), AW'(4));
    check("R7 one unbroken burst", AW'(rises), AW'(1));
    check("R12 no hold with zero count", AW'(hold), '0);
    rd_expect(2'd3, 16'h0001, "R6 done set");
    rd_expect(2'd0, 16'h0104, "R5 addr advanced");
    rd_expect(2'd1, 16'h0000, "R5 count exhausted");
    @(negedge clk); dreq = 0;
    wr(2'd3, 16'h0001);
    rd_expect(2'd3, 16'h0000, "R11 done cleared");

    // burst with slow grant, request dropped mid-block
    lag = 2;
    wr(2'd0, 16'h0200); wr(2'd1, 16'd6); wr(2'd2, 16'b00);
    @(negedge clk); dreq = 1;
    while (ph != 2) @(negedge clk);
    repeat (2) @(negedge clk);
    dreq = 0;
    repeat (6) @(negedge clk);
    check("R9 hold released", AW'(hold), '0);
    rd_expect(2'd1, 16'd3, "R9 count saved");
    rd_expect(2'd0, 16'h0203, "R9 addr saved");
    rd_expect(2'd3, 16'h0000, "R9 not done");
    @(negedge clk); dreq = 1;
    repeat (16) @(negedge clk);
    dreq = 0;
    rd_expect(2'd0, 16'h0206, "R9 resumed to end");
    rd_expect(2'd3, 16'h0001, "R6 done after resume");
    wr(2'd3, 16'h0001);

    // writes during a burst are lost
    lag = 0;
    wr(2'd0, 16'h0300); wr(2'd1, 16'd8); wr(2'd2, 16'b10);
    @(negedge clk); dreq = 1;
    while (ph != 2) @(negedge clk);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'h0077);
    wr(2'd2, 16'h0001);
    repeat (12) @(negedge clk);
    dreq = 0;
    rd_expect(2'd0, 16'h0308, "R10 addr write ignored");
    rd_expect(2'd1, 16'h0000, "R10 count write ignored");
    rd_expect(2'd2, 16'h0002, "R10 ctrl write ignored");
    wr(2'd3, 16'h0001);

    // steal mode, peripheral to memory
    wr(2'd0, 16'h0400); wr(2'd1, 16'd5); wr(2'd2, 16'b01);
    @(negedge clk); dreq = 1;
    n_low = 0; pairs = 0; prev = 1; rises = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk); #(CLK_P/4);
      if (!cpu_clk_en) n_low++;
      if (!cpu_clk_en && !prev) pairs++;
      if (hold) rises++;
      prev = cpu_clk_en;
    end
    check("R8 stolen cycles", AW'(n_low), AW'(5));
    check("R8 no back-to-back steal", AW'(pairs), '0);
    check("R8 no hold in steal mode", AW'(rises), '0);
    @(negedge clk); dreq = 0;
    rd_expect(2'd0, 16'h0405, "R5 steal addr");
    rd_expect(2'd3, 16'h0001, "R6 steal done");

    // clear collides with last word: done stays set
    wr(2'd0, 16'h0500); wr(2'd1, 16'd3); wr(2'd2, 16'b00);
    @(negedge clk); dreq = 1;
    while (!(ph == 2 && m_cnt == 1)) @(negedge clk);
    cpu_sel = 2'd3; cpu_wdata = 16'h0001; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
    rd_expect(2'd3, 16'h0001, "R11 set wins over clear");
    @(negedge clk); dreq = 0;
    wr(2'd3, 16'h0001);
    rd_expect(2'd3, 16'h0000, "R11 clear after collision");

    // zero count in steal mode
    wr(2'd2, 16'b01);
    @(negedge clk); dreq = 1;
    n_low = 0; rises = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #(CLK_P/4);
      if (!cpu_clk_en) n_low++;
      if (hold) rises++;
    end
    check("R12 no steal with zero count", AW'(n_low), '0);
    check("R12 no hold with zero count", AW'(rises), '0);
    @(negedge clk); dreq = 0;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule